// File: doc/BRIEF.md
# End-of-Interrupt Broadcast Throttle

This block reacts to end-of-interrupt (EOI) notifications in an I/O interrupt router. Each notification carries a vector. The block walks the redirection table one entry per cycle. For every level-triggered entry whose vector matches, it clears the remote-IRR flag. If the source line of that entry is still active and the entry is unmasked, the block asks the delivery logic for another service pass.

A stuck level-triggered source can cause a flood of interrupts. To guard against this, each pin has a saturating counter of back-to-back immediate re-deliveries. When the counter reaches a programmable limit, the block clears it and does not request service at once. Instead it arms a single delay timer, and service is requested when that timer expires.

EOIs come from two places: a broadcast from the local interrupt controller, and an explicit write through the register window. A write through the window only counts when it is a full 32-bit write and the configured version is 0x20. An EOI that arrives during a scan waits in a one-entry buffer.

Top module: `eoi_throttle_top`

## Requirements
- R1: Only entries with `rd_level`=1 (level mode) and `rd_vec` equal to the EOI vector are considered. Edge-mode entries and entries with a different vector are never cleared and cause no service request.
- R2: A matching entry whose `rd_rirr` is 0 produces no clear, and its re-delivery counter keeps its value.
- R3: After an EOI is accepted at a clock edge, entries are scanned in ascending order, one per cycle. The clear for entry k shows on `rirr_clr`/`rirr_clr_idx` for one cycle, k+1 cycles after the accepting edge.
- R4: When a clear happens and the entry is unmasked (`rd_masked`=0) with its `irr_lines` bit at 1, the pin counter increments and `svc_req` pulses in the same cycle as the clear. If the entry is masked or its line is low, no request is made and the counter returns to 0.
- R5: When the incremented count reaches STORM_LIMIT, the counter returns to 0 and no immediate request is made. `svc_req` instead pulses DELAY_CYCLES cycles after the cycle in which that clear appears.
- R6: A deferral that arrives while the delay timer is running is absorbed. The earlier deadline stands and only one pulse is produced.
- R7: A `cnt_clr` pulse sets the counter of pin `cnt_clr_idx` to 0. This takes priority over a scan update in the same cycle.
- R8: `bcast_eoi` is always accepted. `win_eoi` is accepted only when `win_eoi_full_word`=1 and `ver_id`=0x20; otherwise it has no effect.
- R9: An EOI accepted during a scan is held and scanned right after the current scan ends. Further EOIs that arrive while that buffer is full are dropped.
- R10: No pin counter ever holds a value of STORM_LIMIT or more.
- R11: After reset, `svc_req` and `rirr_clr` are 0 and `rd_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bcast_eoi | input | 1 | EOI broadcast strobe |
| win_eoi | input | 1 | EOI written through the register window |
| win_eoi_full_word | input | 1 | The window write was 32 bits wide |
| ver_id | input | 8 | Configured version of the router |
| eoi_vec | input | VEC_W | Vector carried by the EOI |
| rd_idx | output | IDX_W | Table entry being read |
| rd_vec | input | VEC_W | Vector field of entry `rd_idx` |
| rd_level | input | 1 | Trigger mode of entry, 1 = level |
| rd_masked | input | 1 | Mask flag of entry |
| rd_rirr | input | 1 | Remote-IRR flag of entry |
| irr_lines | input | NUM_PINS | Current request latch per pin |
| cnt_clr | input | 1 | A redirection entry was written |
| cnt_clr_idx | input | IDX_W | Pin whose entry was written |
| rirr_clr | output | 1 | Clear the remote-IRR flag of an entry |
| rirr_clr_idx | output | IDX_W | Entry to clear |
| svc_req | output | 1 | Service pass request pulse |

## Verification
The assertions assume three things about the inputs. The table read port answers combinationally for whichever entry `rd_idx` names. `cnt_clr_idx` is always below NUM_PINS. DELAY_CYCLES is at least 2. The bench meets these by serving the table from its own model arrays, addressed directly by `rd_idx`, and by issuing counter clears only for pins that exist. It applies the clears at the falling edge, so the entry being scanned never changes under the block. Random runs use a small pool of vectors so that matches, storms and deferrals happen often. Each random run waits for the scan and any pending timer to finish before the next EOI.

// File: rtl/eoi_thr_pkg.sv
package eoi_thr_pkg;

    localparam logic [7:0] EXPL_EOI_VERSION = 8'h20;

    typedef struct packed {
        logic clr;
        logic now;
        logic defer;
    } pin_act_t;

endpackage

// File: rtl/eoi_intake.sv
module eoi_intake
    import eoi_thr_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bcast_eoi,
    input  logic             win_eoi,
    input  logic             win_eoi_full_word,
    input  logic [7:0]       ver_id,
    input  logic [VEC_W-1:0] eoi_vec,
    input  logic             scan_busy,
    input  logic             scan_last,
    output logic             launch,
    output logic [VEC_W-1:0] launch_vec
);

    typedef struct packed {
        logic             pend_v;
        logic [VEC_W-1:0] pend_vec;
    } intake_st_t;

    intake_st_t st_d, st_q;
    logic       win_ok;
    logic       take;

    always_comb begin
        st_d       = st_q;
        win_ok     = win_eoi && win_eoi_full_word && (ver_id == EXPL_EOI_VERSION);
        take       = bcast_eoi || win_ok;
        launch     = 1'b0;
        launch_vec = eoi_vec;
        if (!scan_busy) begin
            launch = take;
        end else if (scan_last) begin
            if (st_q.pend_v) begin
                launch        = 1'b1;
                launch_vec    = st_q.pend_vec;
                st_d.pend_v   = take;
                st_d.pend_vec = eoi_vec;
            end else begin
                launch = take;
            end
        end else if (take && !st_q.pend_v) begin
            st_d.pend_v   = 1'b1;
            st_d.pend_vec = eoi_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_WIN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_busy && !bcast_eoi && win_eoi && !win_eoi_full_word) |-> !launch); // R8

    AST_QUEUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_busy && !scan_last && st_q.pend_v) |=> (st_q.pend_v && st_q.pend_vec == $past(st_q.pend_vec))); // R9

endmodule

// File: rtl/eoi_scanner.sv
module eoi_scanner
    import eoi_thr_pkg::*;
#(
    parameter int NUM_PINS    = 24,
    parameter int VEC_W       = 8,
    parameter int CNT_W       = 14,
    parameter int STORM_LIMIT = 10000,
    localparam int IDX_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic [VEC_W-1:0]    launch_vec,
    output logic                scan_busy,
    output logic                scan_last,
    output logic [IDX_W-1:0]    rd_idx,
    input  logic [VEC_W-1:0]    rd_vec,
    input  logic                rd_level,
    input  logic                rd_masked,
    input  logic                rd_rirr,
    input  logic [NUM_PINS-1:0] irr_lines,
    input  logic                cnt_clr,
    input  logic [IDX_W-1:0]    cnt_clr_idx,
    output logic                rirr_clr,
    output logic [IDX_W-1:0]    rirr_clr_idx,
    output logic                svc_now,
    output logic                defer_req
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PINS - 1);
    localparam logic [CNT_W-1:0] LIMIT_C  = CNT_W'(STORM_LIMIT);

    typedef struct packed {
        logic                           busy;
        logic [IDX_W-1:0]               idx;
        logic [VEC_W-1:0]               vec;
        logic [NUM_PINS-1:0][CNT_W-1:0] cnt;
        logic                           clr_v;
        logic [IDX_W-1:0]               clr_idx;
        logic                           now_v;
    } scan_st_t;

    scan_st_t   st_d, st_q;
    pin_act_t   act;
    logic       hit;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        st_d      = st_q;
        act       = '0;
        hit       = st_q.busy && rd_level && (rd_vec == st_q.vec) && rd_rirr;
        cnt_inc   = st_q.cnt[st_q.idx] + CNT_W'(1);
        st_d.clr_v   = 1'b0;
        st_d.now_v   = 1'b0;
        st_d.clr_idx = st_q.idx;

        if (hit) begin
            act.clr = 1'b1;
            if (!rd_masked && irr_lines[st_q.idx]) begin
                if (cnt_inc >= LIMIT_C) begin
                    act.defer = 1'b1;
                    st_d.cnt[st_q.idx] = '0;
                end else begin
                    act.now = 1'b1;
                    st_d.cnt[st_q.idx] = cnt_inc;
                end
            end else begin
                st_d.cnt[st_q.idx] = '0;
            end
        end
        st_d.clr_v = act.clr;
        st_d.now_v = act.now;

        if (cnt_clr && (int'(cnt_clr_idx) < NUM_PINS)) begin
            st_d.cnt[cnt_clr_idx] = '0;
        end

        if (launch) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
            st_d.vec  = launch_vec;
        end else if (st_q.busy && st_q.idx == LAST_IDX) begin
            st_d.busy = 1'b0;
            st_d.idx  = '0;
        end else if (st_q.busy) begin
            st_d.idx = st_q.idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign scan_busy    = st_q.busy;
    assign scan_last    = st_q.busy && (st_q.idx == LAST_IDX);
    assign rd_idx       = st_q.idx;
    assign rirr_clr     = st_q.clr_v;
    assign rirr_clr_idx = st_q.clr_idx;
    assign svc_now      = st_q.now_v;
    assign defer_req    = act.defer;

    AST_CLR_FROM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rirr_clr |-> $past(rd_level && rd_rirr && rd_vec == st_q.vec && st_q.busy)); // R1

    AST_NOW_WITH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        svc_now |-> (rirr_clr && $past(!rd_masked))); // R4

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt[st_q.idx] < LIMIT_C); // R10

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (st_q.cnt[$past(cnt_clr_idx)] == '0)); // R7

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_idx) < NUM_PINS); // R3

endmodule

// File: rtl/storm_timer.sv
module storm_timer #(
    parameter int DELAY_CYCLES = 2500000,
    localparam int TW          = $clog2(DELAY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic defer_req,
    output logic fire
);

    typedef struct packed {
        logic [TW-1:0] tmr;
        logic          fire;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        if (st_q.tmr != '0) begin
            st_d.tmr  = st_q.tmr - TW'(1);
            st_d.fire = (st_q.tmr == TW'(1));
        end else if (defer_req) begin
            st_d.tmr = TW'(DELAY_CYCLES);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire = st_q.fire;

    AST_KEEP_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tmr > TW'(1) && defer_req) |=> (st_q.tmr == $past(st_q.tmr) - TW'(1))); // R6

    AST_ARM_ON_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tmr == '0 && defer_req) |=> (st_q.tmr == TW'(DELAY_CYCLES))); // R5

endmodule

// File: rtl/eoi_throttle_top.sv
module eoi_throttle_top #(
    parameter int NUM_PINS     = 24,
    parameter int VEC_W        = 8,
    parameter int CNT_W        = 14,
    parameter int STORM_LIMIT  = 10000,
    parameter int DELAY_CYCLES = 2500000,
    localparam int IDX_W       = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bcast_eoi,
    input  logic                win_eoi,
    input  logic                win_eoi_full_word,
    input  logic [7:0]          ver_id,
    input  logic [VEC_W-1:0]    eoi_vec,
    output logic [IDX_W-1:0]    rd_idx,
    input  logic [VEC_W-1:0]    rd_vec,
    input  logic                rd_level,
    input  logic                rd_masked,
    input  logic                rd_rirr,
    input  logic [NUM_PINS-1:0] irr_lines,
    input  logic                cnt_clr,
    input  logic [IDX_W-1:0]    cnt_clr_idx,
    output logic                rirr_clr,
    output logic [IDX_W-1:0]    rirr_clr_idx,
    output logic                svc_req
);

    logic             scan_busy;
    logic             scan_last;
    logic             launch;
    logic [VEC_W-1:0] launch_vec;
    logic             svc_now;
    logic             defer_req;
    logic             fire;

    eoi_intake #(.VEC_W(VEC_W)) u_intake (
        .clk               (clk),
        .rst_n             (rst_n),
        .bcast_eoi         (bcast_eoi),
        .win_eoi           (win_eoi),
        .win_eoi_full_word (win_eoi_full_word),
        .ver_id            (ver_id),
        .eoi_vec           (eoi_vec),
        .scan_busy         (scan_busy),
        .scan_last         (scan_last),
        .launch            (launch),
        .launch_vec        (launch_vec)
    );

    eoi_scanner #(
        .NUM_PINS    (NUM_PINS),
        .VEC_W       (VEC_W),
        .CNT_W       (CNT_W),
        .STORM_LIMIT (STORM_LIMIT)
    ) u_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch       (launch),
        .launch_vec   (launch_vec),
        .scan_busy    (scan_busy),
        .scan_last    (scan_last),
        .rd_idx       (rd_idx),
        .rd_vec       (rd_vec),
        .rd_level     (rd_level),
        .rd_masked    (rd_masked),
        .rd_rirr      (rd_rirr),
        .irr_lines    (irr_lines),
        .cnt_clr      (cnt_clr),
        .cnt_clr_idx  (cnt_clr_idx),
        .rirr_clr     (rirr_clr),
        .rirr_clr_idx (rirr_clr_idx),
        .svc_now      (svc_now),
        .defer_req    (defer_req)
    );

    storm_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .defer_req (defer_req),
        .fire      (fire)
    );

    assign svc_req = svc_now | fire;

    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!svc_req && !rirr_clr)); // R11

endmodule

// File: tb/test_eoi_throttle_top.sv
module test_eoi_throttle_top;
    localparam int NP  = 24;
    localparam int VW  = 8;
    localparam int CW  = 14;
    localparam int LIM = 4;
    localparam int DLY = 40;
    localparam int IW  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          bcast_eoi = 0, win_eoi = 0, win_eoi_full_word = 0, cnt_clr = 0;
    logic [7:0]    ver_id = 8'h20;
    logic [VW-1:0] eoi_vec = '0;
    logic [IW-1:0] cnt_clr_idx = '0;
    logic [IW-1:0] rd_idx, rirr_clr_idx;
    logic [VW-1:0] rd_vec;
    logic          rd_level, rd_masked, rd_rirr, rirr_clr, svc_req;
    logic [NP-1:0] irr = '0;

    logic [VW-1:0] t_vec [NP];
    logic          t_lvl [NP];
    logic          t_msk [NP];
    logic          t_rirr[NP];
    int            mcnt  [NP];

    int total = 0, bad = 0, rel = 0;
    int pulses[$];
    logic [NP-1:0] clr_seen = '0;

    assign rd_vec    = t_vec[rd_idx];
    assign rd_level  = t_lvl[rd_idx];
    assign rd_masked = t_msk[rd_idx];
    assign rd_rirr   = t_rirr[rd_idx];

    eoi_throttle_top #(.NUM_PINS(NP), .VEC_W(VW), .CNT_W(CW),
                       .STORM_LIMIT(LIM), .DELAY_CYCLES(DLY)) i_eoi_throttle_top (
        .clk(clk), .rst_n(rst_n), .bcast_eoi(bcast_eoi), .win_eoi(win_eoi),
        .win_eoi_full_word(win_eoi_full_word), .ver_id(ver_id), .eoi_vec(eoi_vec),
        .rd_idx(rd_idx), .rd_vec(rd_vec), .rd_level(rd_level), .rd_masked(rd_masked),
        .rd_rirr(rd_rirr), .irr_lines(irr), .cnt_clr(cnt_clr), .cnt_clr_idx(cnt_clr_idx),
        .rirr_clr(rirr_clr), .rirr_clr_idx(rirr_clr_idx), .svc_req(svc_req)
    );

    always @(posedge clk) rel = rel + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (svc_req) pulses.push_back(rel);
            if (rirr_clr) begin
                clr_seen[rirr_clr_idx] = 1'b1;
                t_rirr[rirr_clr_idx]   = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_pin(input int k, input logic [7:0] v, input logic lvl,
                           input logic msk, input logic ri, input logic hot);
        t_vec[k] = v; t_lvl[k] = lvl; t_msk[k] = msk; t_rirr[k] = ri; irr[k] = hot;
    endtask

    task automatic clear_count(input int k);
        @(negedge clk);
        cnt_clr = 1'b1; cnt_clr_idx = IW'(k);
        @(negedge clk);
        cnt_clr = 1'b0;
        mcnt[k] = 0;
    endtask

    // kind: 0 broadcast, 1 good window write, 2 short window write, 3 wrong version
    task automatic run_eoi(input logic [7:0] v, input int kind, input string tag);
        int exp_p[$];
        logic [NP-1:0] exp_c;
        int dl;
        dl = -1; exp_c = '0;
        if (kind < 2) begin
            for (int k = 0; k < NP; k++) begin
                if (t_vec[k] == v && t_lvl[k] && t_rirr[k]) begin
                    exp_c[k] = 1'b1;
                    if (!t_msk[k] && irr[k]) begin
                        if (mcnt[k] + 1 >= LIM) begin
                            mcnt[k] = 0;
                            if (dl < 0) dl = k + 2 + DLY;
                        end else begin
                            mcnt[k] = mcnt[k] + 1;
                            exp_p.push_back(k + 2);
                        end
                    end else begin
                        mcnt[k] = 0;
                    end
                end
            end
        end
        if (dl >= 0) exp_p.push_back(dl);
        @(negedge clk);
        pulses.delete(); clr_seen = '0; rel = 0;
        eoi_vec = v;
        ver_id = (kind == 3) ? 8'h11 : 8'h20;
        bcast_eoi = (kind == 0);
        win_eoi = (kind != 0);
        win_eoi_full_word = (kind != 2);
        @(negedge clk);
        bcast_eoi = 0; win_eoi = 0; win_eoi_full_word = 0;
        repeat (NP + DLY + 6) @(negedge clk);
        chk(pulses.size() == exp_p.size(), {tag, " pulse count"}, pulses.size(), exp_p.size());
        for (int i = 0; i < pulses.size() && i < exp_p.size(); i++)
            chk(pulses[i] == exp_p[i], {tag, " pulse time"}, pulses[i], exp_p[i]);
        chk(clr_seen == exp_c, {tag, " clears"}, int'(clr_seen), int'(exp_c));
    endtask

    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < NP; k++) begin
            set_pin(k, 8'h80 + 8'(k), 1'b1, 1'b0, 1'b0, 1'b0);
            mcnt[k] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(svc_req == 0, "R11 svc_req", svc_req, 0);
        chk(rirr_clr == 0, "R11 rirr_clr", rirr_clr, 0);
        chk(rd_idx == 0, "R11 rd_idx", rd_idx, 0);

        // R3 R4 one clear with immediate service
        set_pin(3, 8'h31, 1, 0, 1, 1);
        run_eoi(8'h31, 0, "R3 R4 basic");

        // R1 edge entry and other vector untouched; R2 pin3 already clear
        set_pin(5, 8'h31, 0, 0, 1, 1);
        set_pin(6, 8'h32, 1, 0, 1, 1);
        run_eoi(8'h31, 0, "R1 R2 skip");
        chk(t_rirr[5] == 1, "R1 edge entry kept", t_rirr[5], 1);
        chk(t_rirr[6] == 1, "R1 other vector kept", t_rirr[6], 1);

        // R5 storm on pin3, R2 interleaved no-op EOIs keep the count
        for (int n = 0; n < 5; n++) begin
            t_rirr[3] = 1;
            run_eoi(8'h31, 0, "R5 storm");
            run_eoi(8'h31, 0, "R2 count kept");
        end

        // R4 masked entry: cleared, no service, count reset
        t_msk[3] = 1; t_rirr[3] = 1;
        run_eoi(8'h31, 0, "R4 masked");
        t_msk[3] = 0;
        for (int n = 0; n < 3; n++) begin
            t_rirr[3] = 1;
            run_eoi(8'h31, 0, "R4 after reset");
        end

        // R6 two deferrals in one scan
        set_pin(8, 8'h44, 1, 0, 1, 1);
        set_pin(9, 8'h44, 1, 0, 1, 1);
        for (int n = 0; n < 4; n++) begin
            t_rirr[8] = 1; t_rirr[9] = 1;
            run_eoi(8'h44, 0, "R6 deadline");
        end

        // R7 counter clear by entry write
        set_pin(9, 8'h45, 1, 0, 0, 0);
        for (int n = 0; n < 3; n++) begin
            t_rirr[8] = 1;
            run_eoi(8'h44, 0, "R7 fill");
        end
        clear_count(8);
        t_rirr[8] = 1;
        run_eoi(8'h44, 0, "R7 cleared");

        // R8 window gating
        set_pin(14, 8'h70, 1, 0, 1, 1);
        run_eoi(8'h70, 2, "R8 short write");
        run_eoi(8'h70, 3, "R8 wrong version");
        chk(t_rirr[14] == 1, "R8 entry kept", t_rirr[14], 1);
        run_eoi(8'h70, 1, "R8 good window");

        // R9 queued EOI and dropped third
        set_pin(10, 8'h61, 1, 0, 1, 1);
        set_pin(11, 8'h62, 1, 0, 1, 1);
        set_pin(12, 8'h63, 1, 0, 1, 1);
        @(negedge clk);
        pulses.delete(); clr_seen = '0; rel = 0;
        eoi_vec = 8'h61; bcast_eoi = 1;
        @(negedge clk); bcast_eoi = 0;
        repeat (4) @(negedge clk);
        eoi_vec = 8'h62; bcast_eoi = 1;
        @(negedge clk); eoi_vec = 8'h63;
        @(negedge clk); bcast_eoi = 0;
        repeat (NP * 2 + 8) @(negedge clk);
        mcnt[10]++; mcnt[11]++;
        chk(clr_seen == 24'h000C00, "R9 clears", int'(clr_seen), 24'h000C00);
        chk(pulses.size() == 2, "R9 pulse count", pulses.size(), 2);
        if (pulses.size() == 2) begin
            chk(pulses[0] == 12, "R9 first scan time", pulses[0], 12);
            chk(pulses[1] == 37, "R9 queued scan time", pulses[1], 37);
        end
        chk(t_rirr[12] == 1, "R9 dropped EOI", t_rirr[12], 1);
        run_eoi(8'h63, 0, "R9 later EOI");

        // random mix: R1 R2 R4 R5 R7 R8
        for (int it = 0; it < 150; it++) begin
            int k;
            k = 16 + int'($urandom % 8);
            set_pin(k, 8'h50 + 8'($urandom % 4), 1'($urandom % 4 != 0),
                    1'($urandom % 8 == 0), 1'($urandom % 2), 1'($urandom % 4 != 0));
            clear_count(k);
            for (int j = 16; j < NP; j++) begin
                if ($urandom % 3 == 0) t_rirr[j] = 1;
                if ($urandom % 5 == 0) irr[j] = ~irr[j];
            end
            run_eoi(8'h50 + 8'($urandom % 4), int'($urandom % 4), "R5 R8 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule